// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

This block holds a bank of 64-bit performance counters behind a 32-bit register port with single-cycle access. Each counter is given an 8-bit event code, which selects what it counts: the clock, or data beats on one of two ports, read or write. A counter advances only under three conditions. The global run bit must be set, the counter's own enable bit must be set, and the power-management hold bit must be set. Software can preload either half of any counter and read it back in two 32-bit accesses. The high half is captured when the low half is read, so the two halves always belong to the same 64-bit value.

A counter that rolls over from all-ones to zero raises its pending bit. Pending bits are cleared by writing ones to a separate clear register. A per-counter mask decides which pending bits reach the single interrupt line, and a set mask bit blocks that counter. A read-only identifier register reports a build-time version value.

Top module: `evt_cnt_unit`

## Requirements
- R1: After a synchronous reset the following hold. Counters, run bit, enables, pending bits, hold bit, event codes, `bus_rdata`, `irq_o` and `pm_hold_o` are all zero. The mask reads 0xFF, with every counter masked. Address 0x1CF0 reads the `VERSION` parameter.
- R2: Counter n advances by exactly one on a clock edge only when all of the following are set: bit 0 of 0x1C00 (run), bit n of 0x1C04 (enable), bit 9 of 0x0534 (hold), and its selected event. In every other case it keeps its value.
- R3: Event codes and what they count: 0x00 counts every cycle; 0xE1 counts `evt_i[0]`; 0xE2 counts `evt_i[1]`; 0x61 counts `evt_i[2]`; 0x62 counts `evt_i[3]`. Any other code never counts.
- R4: Counters 0 to 3 take their codes from 0x1C80 and counters 4 to 7 from 0x1C84. Counter n uses bits [8·(n mod 4)+7 : 8·(n mod 4)] of its register. Both registers read back as written.
- R5: The low word of counter n is at 0x1D00+8n and the high word at 0x1D04+8n, and both are writable. A write to a counter in the same cycle as an increment wins, and that increment is lost.
- R6: Reading the low word captures the high word of the same counter at that moment. A later read of any high-word address returns that captured value, even if the counter has carried since.
- R7: While the run bit is clear, counter values do not change except through bus writes.
- R8: A rollover of counter n sets bit n of 0x1C78, whether or not the counter is masked. Writes to 0x1C78 are ignored.
- R9: Writing 1 to bit n of 0x1C7C clears pending bit n. Zero bits leave their pending bits alone. A rollover in the same cycle as its clear leaves the bit set. 0x1C7C reads as zero.
- R10: `irq_o` is high one cycle after any pending bit whose mask bit in 0x1C70 is 0 (1 masks, 0 passes). It is low one cycle after no such bit remains.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_re`. Unmapped addresses read zero, and `bus_rdata` is zero in any cycle that follows no read.
- R12: Bit 9 of 0x0534 reads back as written and drives `pm_hold_o`. The other bits of that register read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W (16) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| evt_i | input | 4 | Event pulses: port-0 write, port-0 read, port-1 write, port-1 read |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Registered interrupt request |
| pm_hold_o | output | 1 | Power-management hold bit, set means power management is off |

## Verification
The bench builds the unit with its default parameters: eight counters, a 32-bit data word and a 16-bit address. With these defaults the full select layout is exercised, including both code registers and an unimplemented code. Rollover at 64 bits is reached in a few cycles by preloading a counter just below all-ones through the bus, instead of counting up to it. The same preload makes the high-word capture observable, because a carry into the upper half can be forced between the two halves of a read.

// File: rtl/evcu_pkg.sv
package evcu_pkg;

  localparam int EVT_NUM  = 4;
  localparam int EV_P0_WR = 0;
  localparam int EV_P0_RD = 1;
  localparam int EV_P1_WR = 2;
  localparam int EV_P1_RD = 3;

  typedef logic [7:0] ev_code_t;

  localparam ev_code_t CODE_CYCLES = 8'h00;
  localparam ev_code_t CODE_P1_WR  = 8'h61;
  localparam ev_code_t CODE_P1_RD  = 8'h62;
  localparam ev_code_t CODE_P0_WR  = 8'hE1;
  localparam ev_code_t CODE_P0_RD  = 8'hE2;

  localparam logic [15:0] OFS_RUN   = 16'h1C00;
  localparam logic [15:0] OFS_ENA   = 16'h1C04;
  localparam logic [15:0] OFS_MASK  = 16'h1C70;
  localparam logic [15:0] OFS_PEND  = 16'h1C78;
  localparam logic [15:0] OFS_CLR   = 16'h1C7C;
  localparam logic [15:0] OFS_SEL   = 16'h1C80;
  localparam logic [15:0] OFS_IDENT = 16'h1CF0;
  localparam logic [15:0] OFS_CNT   = 16'h1D00;
  localparam logic [15:0] OFS_HOLD  = 16'h0534;

  localparam int RUN_BIT  = 0;
  localparam int HOLD_BIT = 9;

endpackage

// File: rtl/evcu_evsel.sv
module evcu_evsel
  import evcu_pkg::*;
(
  input  ev_code_t             code_i,
  input  logic [EVT_NUM-1:0]   evt_i,
  output logic                 hit_o
);

  always_comb begin
    case (code_i)
      CODE_CYCLES: hit_o = 1'b1;
      CODE_P0_WR:  hit_o = evt_i[EV_P0_WR];
      CODE_P0_RD:  hit_o = evt_i[EV_P0_RD];
      CODE_P1_WR:  hit_o = evt_i[EV_P1_WR];
      CODE_P1_RD:  hit_o = evt_i[EV_P1_RD];
      default:     hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/evcu_counter.sv
module evcu_counter #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [FULL_W-1:0] cnt_o,
  output logic              wrap_o
);

  logic [FULL_W-1:0] cnt_q;
  logic              wr_any;

  assign wr_any = wr_lo_i | wr_hi_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_any) begin
      if (wr_lo_i) cnt_q[HALF_W-1:0]      <= wdata_i;
      if (wr_hi_i) cnt_q[FULL_W-1:HALF_W] <= wdata_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + FULL_W'(1);
    end
  end

  // rollover happens on the edge that takes all-ones to zero
  assign wrap_o = inc_i & ~wr_any & (&cnt_q);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/evt_cnt_unit.sv
module evt_cnt_unit
  import evcu_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [EVT_NUM-1:0]   evt_i,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_o,
  output logic                 pm_hold_o
);

  localparam int CNT_W       = 2 * DATA_W;
  localparam int SEL_PER_REG = DATA_W / 8;
  localparam int IDX_W       = ADDR_W - 3;

  localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(OFS_RUN);
  localparam logic [ADDR_W-1:0] A_ENA   = ADDR_W'(OFS_ENA);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(OFS_IDENT);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_HOLD  = ADDR_W'(OFS_HOLD);
  localparam logic [ADDR_W-1:0] CNT_SPAN = ADDR_W'(8 * NUM_CNT);

  logic                 run_q, hold_q, count_go;
  logic [NUM_CNT-1:0]   ena_q, mask_q, pend_q;
  logic [NUM_CNT-1:0]   hit, inc, wrap, wr_lo, wr_hi, clr_vec;
  ev_code_t             code_q [NUM_CNT];
  logic [CNT_W-1:0]     cnt_val [NUM_CNT];
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [DATA_W-1:0]    hi_shadow_q, hi_capture, rd_val;
  logic                 rd_lo_hit;
  logic [ADDR_W-1:0]    cnt_rel;
  logic [IDX_W-1:0]     cnt_idx;
  logic                 in_cnt;

  // ---------------- address decode for the counter window
  assign cnt_rel = bus_addr - A_CNT;
  assign cnt_idx = cnt_rel[ADDR_W-1:3];
  assign in_cnt  = (bus_addr >= A_CNT) && (cnt_rel < CNT_SPAN) && (cnt_rel[1:0] == 2'b00);

  assign count_go = run_q & hold_q;
  assign clr_vec  = (bus_we && bus_addr == A_CLR) ? bus_wdata[NUM_CNT-1:0] : '0;

  // ---------------- control and status registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      ena_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          A_RUN:   run_q  <= bus_wdata[RUN_BIT];
          A_ENA:   ena_q  <= bus_wdata[NUM_CNT-1:0];
          A_MASK:  mask_q <= bus_wdata[NUM_CNT-1:0];
          A_HOLD:  hold_q <= bus_wdata[HOLD_BIT];
          default: ;
        endcase
      end
      // rollover wins over a clear landing in the same cycle
      pend_q <= (pend_q & ~clr_vec) | wrap;
    end
  end

  // ---------------- per-counter slices
  for (genvar n = 0; n < NUM_CNT; n++) begin : g_slice
    localparam int BYTE_POS = n % SEL_PER_REG;
    localparam logic [ADDR_W-1:0] SEL_A = A_SEL + ADDR_W'(4 * (n / SEL_PER_REG));

    always_ff @(posedge clk) begin
      if (rst)                             code_q[n] <= CODE_CYCLES;
      else if (bus_we && bus_addr == SEL_A) code_q[n] <= bus_wdata[8*BYTE_POS +: 8];
    end

    evcu_evsel u_sel (
      .code_i (code_q[n]),
      .evt_i  (evt_i),
      .hit_o  (hit[n])
    );

    assign inc[n]   = count_go & ena_q[n] & hit[n];
    assign wr_lo[n] = bus_we && in_cnt && (cnt_idx == IDX_W'(n)) && !cnt_rel[2];
    assign wr_hi[n] = bus_we && in_cnt && (cnt_idx == IDX_W'(n)) &&  cnt_rel[2];

    evcu_counter #(.HALF_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .inc_i   (inc[n]),
      .wr_lo_i (wr_lo[n]),
      .wr_hi_i (wr_hi[n]),
      .wdata_i (bus_wdata),
      .cnt_o   (cnt_val[n]),
      .wrap_o  (wrap[n])
    );

    assign cnt_flat[n*CNT_W +: CNT_W] = cnt_val[n];
  end

  // ---------------- read multiplexer
  always_comb begin
    rd_val     = '0;
    rd_lo_hit  = 1'b0;
    hi_capture = hi_shadow_q;
    case (bus_addr)
      A_RUN:   rd_val[RUN_BIT]       = run_q;
      A_ENA:   rd_val[NUM_CNT-1:0]   = ena_q;
      A_MASK:  rd_val[NUM_CNT-1:0]   = mask_q;
      A_PEND:  rd_val[NUM_CNT-1:0]   = pend_q;
      A_IDENT: rd_val                = VERSION;
      A_HOLD:  rd_val[HOLD_BIT]      = hold_q;
      default: ;
    endcase
    for (int n = 0; n < NUM_CNT; n++) begin
      if (bus_addr == A_SEL + ADDR_W'(4 * (n / SEL_PER_REG)))
        rd_val[8*(n % SEL_PER_REG) +: 8] = code_q[n];
      if (in_cnt && cnt_idx == IDX_W'(n)) begin
        if (cnt_rel[2]) begin
          rd_val = hi_shadow_q;
        end else begin
          rd_val     = cnt_val[n][DATA_W-1:0];
          rd_lo_hit  = 1'b1;
          hi_capture = cnt_val[n][CNT_W-1:DATA_W];
        end
      end
    end
  end

  // ---------------- registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      hi_shadow_q <= '0;
      irq_o       <= 1'b0;
    end else begin
      bus_rdata <= bus_re ? rd_val : '0;
      if (bus_re && rd_lo_hit) hi_shadow_q <= hi_capture;
      irq_o <= |(pend_q & ~mask_q);
    end
  end

  assign pm_hold_o = hold_q;

endmodule

// File: rtl/evcu_chk.sv
module evcu_chk
  import evcu_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 16,
  localparam int CNT_W  = 2 * DATA_W
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_we,
  input logic                     bus_re,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic                     irq_o,
  input logic                     run_q,
  input logic [NUM_CNT-1:0]       pend_q,
  input logic [NUM_CNT-1:0]       mask_q,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

  logic               cnt_wr;
  logic [NUM_CNT-1:0] clr_seen;

  assign cnt_wr = bus_we && (bus_addr >= ADDR_W'(OFS_CNT)) &&
                  (bus_addr < ADDR_W'(OFS_CNT) + ADDR_W'(8 * NUM_CNT));
  assign clr_seen = (bus_we && bus_addr == ADDR_W'(OFS_CLR)) ? bus_wdata[NUM_CNT-1:0] : '0;

  AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(pend_q & ~mask_q))));   // R10

  AST_PENDING_ONLY_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_seen)) == '0));   // R9

  AST_RDATA_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));   // R11

  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cnt_wr) |=> $stable(cnt_flat));   // R7

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_step
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
      !cnt_wr |=> ((cnt_flat[n*CNT_W +: CNT_W] == $past(cnt_flat[n*CNT_W +: CNT_W])) ||
                   (cnt_flat[n*CNT_W +: CNT_W] == $past(cnt_flat[n*CNT_W +: CNT_W]) + CNT_W'(1))));   // R2
  end

endmodule

bind evt_cnt_unit evcu_chk #(
  .NUM_CNT (NUM_CNT),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .run_q     (run_q),
  .pend_q    (pend_q),
  .mask_q    (mask_q),
  .cnt_flat  (cnt_flat)
);

// File: tb/evt_cnt_unit_tb_top.sv
module evt_cnt_unit_tb_top;

  localparam logic [31:0] TB_VER = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  evt_i = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        pm_hold_o;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;   // 125 MHz

  evt_cnt_unit #(.NUM_CNT(8), .DATA_W(32), .ADDR_W(16), .VERSION(TB_VER)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_i     (evt_i),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .pm_hold_o (pm_hold_o)
  );

  typedef struct packed {
    logic        rd;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h1CF0, 32'h0, TB_VER,        8'd1},   // R1 identifier
    '{1'b1, 16'h1C70, 32'h0, 32'h0000_00FF, 8'd1},   // R1 mask reset
    '{1'b1, 16'h1C78, 32'h0, 32'h0,         8'd1},
    '{1'b1, 16'h1C00, 32'h0, 32'h0,         8'd1},
    '{1'b1, 16'h1D00, 32'h0, 32'h0,         8'd1},
    '{1'b0, 16'h1C80, 32'h6261_E2E1, 32'h0, 8'd4},   // R4
    '{1'b1, 16'h1C80, 32'h0, 32'h6261_E2E1, 8'd4},
    '{1'b0, 16'h1C84, 32'h5500_62E1, 32'h0, 8'd4},
    '{1'b1, 16'h1C84, 32'h0, 32'h5500_62E1, 8'd4},
    '{1'b0, 16'h1C70, 32'h0000_000F, 32'h0, 8'd10},  // R10
    '{1'b1, 16'h1C70, 32'h0, 32'h0000_000F, 8'd10},
    '{1'b0, 16'h0534, 32'hFFFF_FFFF, 32'h0, 8'd12},  // R12
    '{1'b1, 16'h0534, 32'h0, 32'h0000_0200, 8'd12},
    '{1'b0, 16'h1C78, 32'h0000_00FF, 32'h0, 8'd8},   // R8 write ignored
    '{1'b1, 16'h1C78, 32'h0, 32'h0,         8'd8},
    '{1'b1, 16'h1C7C, 32'h0, 32'h0,         8'd9},   // R9
    '{1'b1, 16'h1000, 32'h0, 32'h0,         8'd11},  // R11 unmapped
    '{1'b0, 16'h1D08, 32'hDEAD_0001, 32'h0, 8'd5},   // R5
    '{1'b0, 16'h1D0C, 32'h0000_BEEF, 32'h0, 8'd5},
    '{1'b1, 16'h1D08, 32'h0, 32'hDEAD_0001, 8'd5},
    '{1'b1, 16'h1D0C, 32'h0, 32'h0000_BEEF, 8'd6},   // R6
    '{1'b0, 16'h1C04, 32'h0000_00A5, 32'h0, 8'd2},   // R2
    '{1'b1, 16'h1C04, 32'h0, 32'h0000_00A5, 8'd2},
    '{1'b0, 16'h1C00, 32'hFFFF_FFFE, 32'h0, 8'd2},
    '{1'b1, 16'h1C00, 32'h0, 32'h0,         8'd2}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [15:0] lo_a(input int n);
    return 16'h1D00 + 16'(8 * n);
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [3:0]  pats [6];
    int          exp_c [8];
    pats = '{4'b0001, 4'b0011, 4'b1100, 4'b0000, 4'b1111, 4'b0101};

    @(negedge clk);
    do_reset();
    check("R1 rdata after reset", 64'(bus_rdata), 64'h0);
    check("R1 irq after reset", 64'(irq_o), 64'h0);
    check("R1 pm_hold after reset", 64'(pm_hold_o), 64'h0);

    // ---------- table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        rd(VECS[i].addr, v);
        nchk++;
        if (v !== VECS[i].exp) begin
          nerr++;
          $display("FAIL R%0d table entry %0d addr=%h actual=%h expected=%h",
                   VECS[i].req, i, VECS[i].addr, v, VECS[i].exp);
        end
      end else begin
        wr(VECS[i].addr, VECS[i].data);
      end
    end
    check("R12 pm_hold_o follows bit 9", 64'(pm_hold_o), 64'h1);
    @(negedge clk);
    check("R11 rdata zero when idle", 64'(bus_rdata), 64'h0);

    // ---------- R2 R3 R4: event selection and counting
    do_reset();
    wr(16'h0534, 32'h0000_0200);
    wr(16'h1C80, 32'h6261_E2E1);
    wr(16'h1C84, 32'h5500_62E1);
    wr(16'h1C04, 32'h0000_00FF);
    wr(16'h1C00, 32'h1);
    for (int p = 0; p < 6; p++) begin
      evt_i = pats[p];
      @(negedge clk);
    end
    evt_i = '0;
    wr(16'h1C00, 32'h0);
    for (int n = 0; n < 8; n++) exp_c[n] = 0;
    for (int p = 0; p < 6; p++) begin
      exp_c[0] += int'(pats[p][0]);
      exp_c[1] += int'(pats[p][1]);
      exp_c[2] += int'(pats[p][2]);
      exp_c[3] += int'(pats[p][3]);
      exp_c[4] += int'(pats[p][0]);
      exp_c[5] += int'(pats[p][3]);
    end
    exp_c[6] = 6 + 1;
    for (int n = 0; n < 8; n++) begin
      rd(lo_a(n), v);
      check($sformatf("R3 R4 counter %0d after pattern", n), 64'(v), 64'(exp_c[n]));
    end

    // R2: a disabled counter keeps its value
    wr(16'h1C04, 32'h0000_00FE);
    wr(16'h1C00, 32'h1);
    evt_i = 4'b0001;
    @(negedge clk);
    evt_i = '0;
    wr(16'h1C00, 32'h0);
    rd(lo_a(0), v);
    check("R2 disabled counter 0 holds", 64'(v), 64'(exp_c[0]));
    rd(lo_a(4), v);
    check("R2 enabled counter 4 advances", 64'(v), 64'(exp_c[4] + 1));

    // R2: hold bit clear stops counting
    wr(16'h0534, 32'h0);
    check("R12 pm_hold_o cleared", 64'(pm_hold_o), 64'h0);
    wr(16'h1C00, 32'h1);
    evt_i = 4'b0001;
    @(negedge clk);
    evt_i = '0;
    wr(16'h1C00, 32'h0);
    rd(lo_a(4), v);
    check("R2 hold bit clear blocks count", 64'(v), 64'(exp_c[4] + 1));

    // R7: stopped counters stay frozen
    rd(lo_a(6), v);
    repeat (5) @(negedge clk);
    begin
      logic [31:0] v2;
      rd(lo_a(6), v2);
      check("R7 counter frozen while stopped", 64'(v2), 64'(v));
    end

    // ---------- R8 R10: rollover under mask
    do_reset();
    wr(16'h0534, 32'h0000_0200);
    wr(lo_a(6), 32'hFFFF_FFFE);
    wr(lo_a(6) + 16'd4, 32'hFFFF_FFFF);
    wr(16'h1C04, 32'h0000_0040);
    wr(16'h1C00, 32'h1);
    @(negedge clk);
    wr(16'h1C00, 32'h0);
    rd(16'h1C78, v);
    check("R8 pending set while masked", 64'(v), 64'h40);
    check("R10 irq low while masked", 64'(irq_o), 64'h0);
    rd(lo_a(6), v);
    check("R8 low word wrapped", 64'(v), 64'h0);
    rd(lo_a(6) + 16'd4, v);
    check("R8 high word wrapped", 64'(v), 64'h0);

    wr(16'h1C70, 32'h0000_00BF);
    check("R10 irq not yet high", 64'(irq_o), 64'h0);
    @(negedge clk);
    check("R10 irq high after unmask", 64'(irq_o), 64'h1);

    wr(16'h1C7C, 32'h0000_00BF);
    rd(16'h1C78, v);
    check("R9 zero bits do not clear", 64'(v), 64'h40);
    wr(16'h1C7C, 32'h0000_0040);
    rd(16'h1C78, v);
    check("R9 one bit clears", 64'(v), 64'h0);
    check("R10 irq drops after clear", 64'(irq_o), 64'h0);

    // R9: rollover beats a clear in the same cycle
    wr(lo_a(6), 32'hFFFF_FFFF);
    wr(lo_a(6) + 16'd4, 32'hFFFF_FFFF);
    wr(16'h1C00, 32'h1);
    wr(16'h1C7C, 32'h0000_0040);
    wr(16'h1C00, 32'h0);
    rd(16'h1C78, v);
    check("R9 set wins over same-cycle clear", 64'(v), 64'h40);
    rd(lo_a(6), v);
    check("R2 counter after rollover and one step", 64'(v), 64'h1);

    // R5: write beats a same-cycle increment
    wr(16'h1C00, 32'h1);
    wr(lo_a(6), 32'h0000_0100);
    wr(16'h1C00, 32'h0);
    rd(lo_a(6), v);
    check("R5 write wins over increment", 64'(v), 64'h101);

    // R6: high word captured on low read
    wr(lo_a(5), 32'hFFFF_FFFF);
    wr(lo_a(5) + 16'd4, 32'h0000_0005);
    rd(lo_a(5), v);
    check("R6 low word before carry", 64'(v), 64'hFFFF_FFFF);
    wr(16'h1C04, 32'h0000_0020);
    wr(16'h1C00, 32'h1);
    wr(16'h1C00, 32'h0);
    rd(lo_a(5) + 16'd4, v);
    check("R6 high read returns captured word", 64'(v), 64'h5);
    rd(lo_a(5), v);
    check("R6 low word after carry", 64'(v), 64'h0);
    rd(lo_a(5) + 16'd4, v);
    check("R6 high word after fresh capture", 64'(v), 64'h6);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule